// File: doc/BRIEF.md
# Virtual Channel Frame Assembler

This block emits a continuous stream of fixed-length transfer frames, one byte per clock, for a downlink serializer. Every frame opens with an 8-byte frame header. Next comes a packet with a 6-byte primary header and a 1-byte secondary header. The rest of the frame is a data space. The frame header carries a frame sequence number. The block keeps this number internally and advances it once per frame. All other header fields come from static configuration inputs.

Packet content has two sources, both read with valid/ready handshakes. At the start of each frame's packet, the block accepts one length descriptor from a side queue. The descriptor gives how many encoded-data bytes and how many LSB bytes the packet holds. Encoded bytes are copied first and LSB bytes after them. Any data-space bytes left over are filled with an idle pattern. If no descriptor is waiting when the packet starts, the whole data space is idle and the packet is marked with the idle application identifier.

The byte output is held in a register and follows a valid/ready handshake. While the downstream side is not ready, the output is held and no byte is lost. With the default frame length of 1100 bytes, the data space is 1085 bytes. At 20 MHz the block sustains 20 MB/s whenever the sources keep up.

Top module: `vcf_assembler`

## Requirements
- R1: Each frame is exactly FRAME_BYTES bytes (default 1100). Frame offsets 0..7 are the frame header, 8..13 the primary header, 14 the secondary header, and 15..FRAME_BYTES-1 the data space. Frames follow one another with no gap bytes, and offsets 0..1 carry `cfg_craft` high byte then low byte.
- R2: Frame header offset 2 is `cfg_chan`, and offsets 4..7 are `cfg_tag` in big-endian order.
- R3: Frame header offset 3 is an 8-bit frame sequence number. It is 0 in the first frame after reset, rises by one per frame and wraps from 255 to 0.
- R4: Primary header offsets 8..9 are `cfg_apid` in big-endian order, or 0x07FF when the frame has no descriptor. Offsets 10..11 are `cfg_pseq` in big-endian order. Offsets 12..13 are the data-field byte count minus one (secondary header plus data space minus one, i.e. FRAME_BYTES-15, 0x043D by default) in big-endian order.
- R5: Offset 14 is `cfg_sec`.
- R6: A descriptor is accepted only as frame offset 8 is produced, at most one per frame. The data space then begins with the encoded bytes in arrival order, followed by the LSB bytes in arrival order.
- R7: Descriptor lengths are clamped. Encoded count = min(`aux_enc_len`, data space). LSB count = min(`aux_lsb_len`, data space − encoded count). Bytes beyond the clamped counts are not consumed.
- R8: Data-space bytes after the packet payload are 0x55. A frame without a descriptor has all data-space bytes at 0x55 and pulls no source byte.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. Every byte is delivered exactly once.
- R10: When a needed source byte is not valid, the output pauses. The pause shows as an empty output slot, not an idle byte, and the byte order is kept.
- R11: While `rst` is high, all ready outputs are low, and `out_valid` is low from the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_craft | input | 16 | Frame header identifier, offsets 0..1 |
| cfg_chan | input | 8 | Channel byte, offset 2 |
| cfg_tag | input | 32 | Frame header tail, offsets 4..7 |
| cfg_apid | input | 16 | Packet application identifier |
| cfg_pseq | input | 16 | Packet sequence/flags field |
| cfg_sec | input | 8 | Secondary header byte |
| aux_valid | input | 1 | Descriptor available |
| aux_ready | output | 1 | Descriptor accepted this cycle when valid |
| aux_enc_len | input | LEN_W | Encoded byte count request |
| aux_lsb_len | input | LEN_W | LSB byte count request |
| enc_valid | input | 1 | Encoded byte valid |
| enc_ready | output | 1 | Encoded byte taken when valid |
| enc_data | input | 8 | Encoded byte |
| lsb_valid | input | 1 | LSB byte valid |
| lsb_ready | output | 1 | LSB byte taken when valid |
| lsb_data | input | 8 | LSB byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte |

## Verification
Six descriptors are tried. One mixes encoded and LSB bytes. One has LSB bytes only. One fills the data space exactly. One over-asks in LSB. One over-asks in encoded. One is random. Together they separate correct ordering and clamping from overruns and from an off-by-one at the idle boundary. Two frames follow with no descriptor, which exposes a wrong idle identifier or a stray source pull. The source valids and the output ready toggle at random, so misplaced bubbles and lost or repeated bytes under stall show up as shifted payloads. A second, short-frame instance runs past 256 frames to show the sequence wrap.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
  localparam int FH_BYTES   = 8;
  localparam int PH_BYTES   = 6;
  localparam int SH_BYTES   = 1;
  localparam int HDR_TOTAL  = FH_BYTES + PH_BYTES + SH_BYTES;
  localparam logic [7:0]  IDLE_BYTE = 8'h55;
  localparam logic [15:0] IDLE_APID = 16'h07FF;

  typedef enum logic [2:0] {
    SEG_FHDR, SEG_PHDR, SEG_SHDR, SEG_ENC, SEG_LSB, SEG_IDLE
  } seg_e;
endpackage

// File: rtl/vcf_seq.sv
module vcf_seq
  import vcf_pkg::*;
#(
  parameter int FRAME_BYTES = 1100,
  parameter int LEN_W       = 11,
  parameter int SEQ_W       = 8,
  parameter int POS_W       = $clog2(FRAME_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             aux_valid,
  input  logic [LEN_W-1:0] aux_enc_len,
  input  logic [LEN_W-1:0] aux_lsb_len,
  output logic [POS_W-1:0] pos,
  output seg_e             seg,
  output logic             pkt_live,
  output logic [SEQ_W-1:0] frame_seq
);
  localparam int DS      = FRAME_BYTES - HDR_TOTAL;
  localparam int LAST    = FRAME_BYTES - 1;
  localparam int PKT_POS = FH_BYTES;

  logic [POS_W-1:0] pos_q, enc_end_q, lsb_end_q;
  logic [POS_W-1:0] enc_end_n, lsb_end_n;
  logic             have_q;
  logic [SEQ_W-1:0] seq_q;
  logic [31:0]      e_req, l_req, e_c, l_c;

  always_comb begin
    e_req = 32'(aux_enc_len);
    l_req = 32'(aux_lsb_len);
    e_c   = (e_req > 32'(DS)) ? 32'(DS) : e_req;
    l_c   = (l_req > (32'(DS) - e_c)) ? (32'(DS) - e_c) : l_req;
    enc_end_n = POS_W'(32'(HDR_TOTAL) + e_c);
    lsb_end_n = POS_W'(32'(HDR_TOTAL) + e_c + l_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      seq_q     <= '0;
      have_q    <= 1'b0;
      enc_end_q <= POS_W'(HDR_TOTAL);
      lsb_end_q <= POS_W'(HDR_TOTAL);
    end else if (step) begin
      if (pos_q == POS_W'(LAST)) begin
        pos_q <= '0;
        seq_q <= seq_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
      if (pos_q == POS_W'(PKT_POS)) begin
        have_q <= aux_valid;
        if (aux_valid) begin
          enc_end_q <= enc_end_n;
          lsb_end_q <= lsb_end_n;
        end else begin
          enc_end_q <= POS_W'(HDR_TOTAL);
          lsb_end_q <= POS_W'(HDR_TOTAL);
        end
      end
    end
  end

  always_comb begin
    if (pos_q < POS_W'(FH_BYTES))                 seg = SEG_FHDR;
    else if (pos_q < POS_W'(FH_BYTES + PH_BYTES)) seg = SEG_PHDR;
    else if (pos_q < POS_W'(HDR_TOTAL))           seg = SEG_SHDR;
    else if (pos_q < enc_end_q)                   seg = SEG_ENC;
    else if (pos_q < lsb_end_q)                   seg = SEG_LSB;
    else                                          seg = SEG_IDLE;
  end

  assign pos       = pos_q;
  assign pkt_live  = (pos_q == POS_W'(PKT_POS)) ? aux_valid : have_q;
  assign frame_seq = seq_q;

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos_q <= POS_W'(LAST));

  // R7
  end_order_chk: assert property (@(posedge clk) disable iff (rst)
    (enc_end_q >= POS_W'(HDR_TOTAL)) && (enc_end_q <= lsb_end_q)
    && (32'(lsb_end_q) <= 32'(FRAME_BYTES)));
endmodule

// File: rtl/vcf_byte_sel.sv
module vcf_byte_sel
  import vcf_pkg::*;
#(
  parameter int FRAME_BYTES = 1100,
  parameter int SEQ_W       = 8,
  parameter int POS_W       = $clog2(FRAME_BYTES)
) (
  input  logic [POS_W-1:0] pos,
  input  seg_e             seg,
  input  logic             pkt_live,
  input  logic [SEQ_W-1:0] frame_seq,
  input  logic [15:0]      cfg_craft,
  input  logic [7:0]       cfg_chan,
  input  logic [31:0]      cfg_tag,
  input  logic [15:0]      cfg_apid,
  input  logic [15:0]      cfg_pseq,
  input  logic [7:0]       cfg_sec,
  input  logic [7:0]       enc_data,
  input  logic [7:0]       lsb_data,
  output logic [7:0]       byte_o
);
  localparam logic [15:0] LEN_FIELD = 16'(FRAME_BYTES - HDR_TOTAL);

  logic [15:0] apid_eff;
  int          idx;

  assign apid_eff = pkt_live ? cfg_apid : IDLE_APID;
  assign idx      = int'(pos);

  always_comb begin
    byte_o = IDLE_BYTE;
    unique case (seg)
      SEG_FHDR, SEG_PHDR, SEG_SHDR: begin
        case (idx)
          0:  byte_o = cfg_craft[15:8];
          1:  byte_o = cfg_craft[7:0];
          2:  byte_o = cfg_chan;
          3:  byte_o = 8'(frame_seq);
          4:  byte_o = cfg_tag[31:24];
          5:  byte_o = cfg_tag[23:16];
          6:  byte_o = cfg_tag[15:8];
          7:  byte_o = cfg_tag[7:0];
          8:  byte_o = apid_eff[15:8];
          9:  byte_o = apid_eff[7:0];
          10: byte_o = cfg_pseq[15:8];
          11: byte_o = cfg_pseq[7:0];
          12: byte_o = LEN_FIELD[15:8];
          13: byte_o = LEN_FIELD[7:0];
          default: byte_o = cfg_sec;
        endcase
      end
      SEG_ENC:  byte_o = enc_data;
      SEG_LSB:  byte_o = lsb_data;
      default:  byte_o = IDLE_BYTE;
    endcase
  end
endmodule

// File: rtl/vcf_out_reg.sv
module vcf_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/vcf_assembler.sv
module vcf_assembler
  import vcf_pkg::*;
#(
  parameter int FRAME_BYTES = 1100,
  parameter int LEN_W       = 11,
  parameter int SEQ_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      cfg_craft,
  input  logic [7:0]       cfg_chan,
  input  logic [31:0]      cfg_tag,
  input  logic [15:0]      cfg_apid,
  input  logic [15:0]      cfg_pseq,
  input  logic [7:0]       cfg_sec,
  input  logic             aux_valid,
  output logic             aux_ready,
  input  logic [LEN_W-1:0] aux_enc_len,
  input  logic [LEN_W-1:0] aux_lsb_len,
  input  logic             enc_valid,
  output logic             enc_ready,
  input  logic [7:0]       enc_data,
  input  logic             lsb_valid,
  output logic             lsb_ready,
  input  logic [7:0]       lsb_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data
);
  localparam int POS_W = $clog2(FRAME_BYTES);

  logic [POS_W-1:0] pos;
  seg_e             seg;
  logic             pkt_live;
  logic [SEQ_W-1:0] frame_seq;
  logic [7:0]       next_byte;
  logic             slot_free, src_ok, step;

  assign slot_free = !out_valid || out_ready;
  assign src_ok    = (seg == SEG_ENC) ? enc_valid :
                     (seg == SEG_LSB) ? lsb_valid : 1'b1;
  assign step      = !rst && slot_free && src_ok;

  assign aux_ready = !rst && slot_free && (pos == POS_W'(FH_BYTES));
  assign enc_ready = !rst && slot_free && (seg == SEG_ENC);
  assign lsb_ready = !rst && slot_free && (seg == SEG_LSB);

  vcf_seq #(.FRAME_BYTES(FRAME_BYTES), .LEN_W(LEN_W), .SEQ_W(SEQ_W), .POS_W(POS_W)) u_seq (
    .clk(clk), .rst(rst), .step(step),
    .aux_valid(aux_valid), .aux_enc_len(aux_enc_len), .aux_lsb_len(aux_lsb_len),
    .pos(pos), .seg(seg), .pkt_live(pkt_live), .frame_seq(frame_seq)
  );

  vcf_byte_sel #(.FRAME_BYTES(FRAME_BYTES), .SEQ_W(SEQ_W), .POS_W(POS_W)) u_sel (
    .pos(pos), .seg(seg), .pkt_live(pkt_live), .frame_seq(frame_seq),
    .cfg_craft(cfg_craft), .cfg_chan(cfg_chan), .cfg_tag(cfg_tag),
    .cfg_apid(cfg_apid), .cfg_pseq(cfg_pseq), .cfg_sec(cfg_sec),
    .enc_data(enc_data), .lsb_data(lsb_data), .byte_o(next_byte)
  );

  vcf_out_reg #(.W(8)) u_out (
    .clk(clk), .rst(rst), .load(step), .d(next_byte),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  // R6
  one_src_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({aux_ready, enc_ready, lsb_ready}));

  // R8
  idle_no_pull_chk: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_IDLE) |-> (!enc_ready && !lsb_ready));

  // R10
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_ENC && !enc_valid) |=> $stable(pos));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/vcf_assembler_bench.sv
module vcf_assembler_bench;
  localparam int FB   = 1100;
  localparam int DS   = FB - 15;
  localparam int SFB  = 32;
  localparam int SDS  = SFB - 15;
  localparam int ND   = 6;
  localparam int NIDLE = 2;
  localparam int NFR  = ND + NIDLE;
  localparam int SNFR = 260;

  localparam logic [15:0] C_CRAFT = 16'hA5C3;
  localparam logic [7:0]  C_CHAN  = 8'h2B;
  localparam logic [31:0] C_TAG   = 32'h1357_9BDF;
  localparam logic [15:0] C_APID  = 16'h0123;
  localparam logic [15:0] C_PSEQ  = 16'hC456;
  localparam logic [7:0]  C_SEC   = 8'h9A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        aux_valid = 0, aux_ready;
  logic [10:0] aux_enc_len = 0, aux_lsb_len = 0;
  logic        enc_valid = 0, enc_ready;
  logic [7:0]  enc_data = 0;
  logic        lsb_valid = 0, lsb_ready;
  logic [7:0]  lsb_data = 0;
  logic        out_valid, out_ready = 0;
  logic [7:0]  out_data;

  logic        s_aux_ready, s_enc_ready, s_lsb_ready, s_out_valid;
  logic [7:0]  s_out_data;

  vcf_assembler #(.FRAME_BYTES(FB)) u_vcf_assembler (
    .clk(clk), .rst(rst),
    .cfg_craft(C_CRAFT), .cfg_chan(C_CHAN), .cfg_tag(C_TAG),
    .cfg_apid(C_APID), .cfg_pseq(C_PSEQ), .cfg_sec(C_SEC),
    .aux_valid(aux_valid), .aux_ready(aux_ready),
    .aux_enc_len(aux_enc_len), .aux_lsb_len(aux_lsb_len),
    .enc_valid(enc_valid), .enc_ready(enc_ready), .enc_data(enc_data),
    .lsb_valid(lsb_valid), .lsb_ready(lsb_ready), .lsb_data(lsb_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  vcf_assembler #(.FRAME_BYTES(SFB)) u_small (
    .clk(clk), .rst(rst),
    .cfg_craft(C_CRAFT), .cfg_chan(C_CHAN), .cfg_tag(C_TAG),
    .cfg_apid(C_APID), .cfg_pseq(C_PSEQ), .cfg_sec(C_SEC),
    .aux_valid(1'b0), .aux_ready(s_aux_ready),
    .aux_enc_len(11'd0), .aux_lsb_len(11'd0),
    .enc_valid(1'b0), .enc_ready(s_enc_ready), .enc_data(8'd0),
    .lsb_valid(1'b0), .lsb_ready(s_lsb_ready), .lsb_data(8'd0),
    .out_valid(s_out_valid), .out_ready(1'b1), .out_data(s_out_data)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // descriptors and stimulus queues
  int d_enc[ND], d_lsb[ND], d_ec[ND], d_lc[ND];
  bit d_clamp[ND];
  logic [7:0] enc_q[$], lsb_q[$], enc_ref[$], lsb_ref[$];
  logic [7:0] exp_b[$], rx_b[$], srx_b[$];
  int         exp_t[$];
  string tag_name[8] = '{"R1", "R2", "R3", "R4", "R5", "R6 R10", "R7", "R8"};

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic push_e(input logic [7:0] b, input int t);
    exp_b.push_back(b);
    exp_t.push_back(t);
  endtask

  task automatic add_frame(input int k, input bit live, input int ec, input int lc,
                           input bit clamped);
    logic [15:0] ap;
    logic [15:0] ln;
    ap = live ? C_APID : 16'h07FF;
    ln = 16'(DS);
    push_e(C_CRAFT[15:8], 0); push_e(C_CRAFT[7:0], 0);
    push_e(C_CHAN, 1);        push_e(8'(k), 2);
    push_e(C_TAG[31:24], 1);  push_e(C_TAG[23:16], 1);
    push_e(C_TAG[15:8], 1);   push_e(C_TAG[7:0], 1);
    push_e(ap[15:8], 3);      push_e(ap[7:0], 3);
    push_e(C_PSEQ[15:8], 3);  push_e(C_PSEQ[7:0], 3);
    push_e(ln[15:8], 3);      push_e(ln[7:0], 3);
    push_e(C_SEC, 4);
    for (int i = 0; i < ec; i++) push_e(enc_ref.pop_front(), clamped ? 6 : 5);
    for (int i = 0; i < lc; i++) push_e(lsb_ref.pop_front(), clamped ? 6 : 5);
    for (int i = ec + lc; i < DS; i++) push_e(8'h55, 7);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit enc_hs, lsb_hs, aux_hs, stall;
    logic [7:0] stall_data;
    int aux_i, stall_events, stall_bad;
    enc_hs = 0; lsb_hs = 0; aux_hs = 0; stall = 0; stall_data = 0;
    aux_i = 0; stall_events = 0; stall_bad = 0;
    void'($urandom(32'd20250611));

    // mixed, lsb only, exact fill of encoded + lsb overflow, encoded overflow, exact fill, random
    d_enc = '{100, 0, 1085, 1200, 1000, 0};
    d_lsb = '{30, 50, 20, 5, 85, 0};
    d_enc[5] = int'($urandom_range(599, 1));
    d_lsb[5] = int'($urandom_range(399, 1));
    for (int d = 0; d < ND; d++) begin
      d_ec[d] = min2(d_enc[d], DS);
      d_lc[d] = min2(d_lsb[d], DS - d_ec[d]);
      d_clamp[d] = (d_ec[d] != d_enc[d]) || (d_lc[d] != d_lsb[d]);
      for (int i = 0; i < d_ec[d]; i++) enc_q.push_back(8'($urandom));
      for (int i = 0; i < d_lc[d]; i++) lsb_q.push_back(8'($urandom));
    end
    enc_ref = enc_q;
    lsb_ref = lsb_q;
    for (int k = 0; k < NFR; k++)
      if (k < ND) add_frame(k, 1'b1, d_ec[k], d_lc[k], d_clamp[k]);
      else        add_frame(k, 1'b0, 0, 0, 1'b0);

    // reset
    repeat (4) @(negedge clk);
    check(!aux_ready && !enc_ready && !lsb_ready, "R11", "readies in reset",
          {aux_ready, enc_ready, lsb_ready}, 0);
    check(!out_valid && !s_out_valid, "R11", "out_valid in reset", out_valid, 0);
    rst = 1'b0;

    while (rx_b.size() < NFR * FB || srx_b.size() < SNFR * SFB) begin
      @(negedge clk);
      if (enc_hs) void'(enc_q.pop_front());
      if (lsb_hs) void'(lsb_q.pop_front());
      if (aux_hs) aux_i++;
      if (stall) begin
        stall_events++;
        if (!(out_valid && out_data == stall_data)) begin
          stall_bad++;
          $display("FAIL R9 stall hold: actual valid=%0b data=0x%0h expected valid=1 data=0x%0h",
                   out_valid, out_data, stall_data);
        end
      end
      out_ready = ($urandom % 4) != 0;
      enc_valid = (enc_q.size() > 0) && (($urandom % 3) != 0);
      enc_data  = (enc_q.size() > 0) ? enc_q[0] : 8'h00;
      lsb_valid = (lsb_q.size() > 0) && (($urandom % 3) != 0);
      lsb_data  = (lsb_q.size() > 0) ? lsb_q[0] : 8'h00;
      aux_valid = aux_i < ND;
      aux_enc_len = (aux_i < ND) ? 11'(d_enc[aux_i]) : 11'd0;
      aux_lsb_len = (aux_i < ND) ? 11'(d_lsb[aux_i]) : 11'd0;
      #1;
      enc_hs = enc_valid && enc_ready;
      lsb_hs = lsb_valid && lsb_ready;
      aux_hs = aux_valid && aux_ready;
      stall  = out_valid && !out_ready;
      stall_data = out_data;
      if (out_valid && out_ready && rx_b.size() < NFR * FB) rx_b.push_back(out_data);
      if (s_out_valid && srx_b.size() < SNFR * SFB) srx_b.push_back(s_out_data);
    end

    // R9: no byte lost or repeated under stall
    check(stall_bad == 0 && stall_events > 0, "R9", "stall hold violations", stall_bad, 0);
    // R6: one descriptor per live frame, none taken in idle frames
    check(aux_i == ND, "R6", "descriptors taken", aux_i, ND);
    // R7: bytes beyond clamped counts are not consumed
    check(enc_q.size() == 0 && lsb_q.size() == 0, "R7", "leftover source bytes",
          enc_q.size() + lsb_q.size(), 0);

    // main instance frame comparison, one check per field group per frame
    for (int f = 0; f < NFR; f++) begin
      bit used[8];
      bit bad[8];
      int fa[8], fe[8];
      for (int t = 0; t < 8; t++) begin used[t] = 0; bad[t] = 0; fa[t] = 0; fe[t] = 0; end
      for (int i = 0; i < FB; i++) begin
        int j, t;
        j = f * FB + i;
        t = exp_t[j];
        used[t] = 1;
        if (rx_b[j] !== exp_b[j] && !bad[t]) begin
          bad[t] = 1; fa[t] = int'(rx_b[j]); fe[t] = int'(exp_b[j]);
        end
      end
      for (int t = 0; t < 8; t++)
        if (used[t])
          check(!bad[t], tag_name[t], $sformatf("frame %0d first mismatch", f), fa[t], fe[t]);
    end

    // short-frame instance: sequence wrap and all-idle frames
    for (int k = 0; k < SNFR; k++) begin
      bit idle_ok;
      int b;
      b = k * SFB;
      check(srx_b[b + 3] == 8'(k), "R3", $sformatf("short frame %0d sequence", k),
            srx_b[b + 3], k % 256);
      idle_ok = 1;
      for (int i = 15; i < SFB; i++) if (srx_b[b + i] != 8'h55) idle_ok = 0;
      check(idle_ok, "R8", $sformatf("short frame %0d idle fill", k), 0, 8'h55);
    end
    check({srx_b[8], srx_b[9]} == 16'h07FF && {srx_b[12], srx_b[13]} == 16'(SDS), "R4",
          "short frame idle id and length", {srx_b[8], srx_b[9], srx_b[12], srx_b[13]},
          {16'h07FF, 16'(SDS)});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule